// File: doc/BRIEF.md
# Bus Tenure Sequencer with Address Retry

This block is the bus-side controller that a processor core uses to run transactions on a bus with separate address and data phases. When the core raises a request, the block arbitrates for the address bus, issues a one-cycle transfer-start strobe, and waits for the address acknowledge. While it waits, it watches the address-retry line. A transfer start also stands for a data-bus request, unless the transaction is address-only. The block takes the data bus only when it sees a qualified grant, and then collects a four-beat burst.

An address retry seen inside the allowed window makes the block drop the tenure. Any data tenure already running is cancelled at once, even when the whole burst has already arrived. The block then asks for the address bus again once the retry line has been released. A retry seen while the block is only requesting, and is not yet master, makes it withdraw its bus request at once so that the snooping master can get onto the bus. A data retry during the burst throws away the beats received so far and waits for the data to be sent again, with no new address tenure. Each completed transaction ends with a one-cycle completion pulse to the core.

All bus control signals are active-low and are sampled on the rising clock edge. The core request and the completion pulse are active-high.

Top module: `bus_tenure_seq`

## Requirements
- R1: After reset, breq_n, tstart_n and dtenure_n are high and tenure_done is low.
- R2: A core request makes breq_n low in the next cycle. An address grant sampled while artry_n is high makes tstart_n low in the next cycle, for exactly one cycle, and breq_n is high from that cycle onward.
- R3: While the block is requesting but not master, artry_n low forces breq_n high in that same cycle and in the following cycle. breq_n goes low again in the cycle after artry_n is sampled high.
- R4: A data tenure starts (dtenure_n low) in the cycle after a qualified grant is sampled. A grant is qualified when dbus_gnt_n is low, dbusy_in_n and drtry_n are high, and the block's own address tenure is not being retried in that cycle.
- R5: Counting the transfer-start cycle as 0, artry_n is honoured from cycle 2 through the cycle after the one in which aack_n is sampled low. It is ignored in cycle 1 and in the second cycle after the acknowledge.
- R6: After an honoured retry, breq_n goes low again in the third cycle after the acknowledge. A new transfer start follows, and the retried attempt produces no completion pulse.
- R7: An honoured retry makes dtenure_n high in the next cycle. This holds even when all four beats have already been received, and the new attempt then needs a full fresh burst.
- R8: A burst is four cycles with ta_n low while dtenure_n is low. dtenure_n goes high in the cycle after the fourth beat.
- R9: tenure_done is high for exactly one cycle. That cycle is the later of the third cycle after the acknowledge and the second cycle after the fourth beat.
- R10: drtry_n low during a burst discards the beats received so far. That cycle's ta_n is not counted, four new beats are needed, and no new transfer start is issued.
- R11: For an address-only request, no data tenure occurs and tenure_done comes in the third cycle after the acknowledge.
- R12: artry_n low after the retry window has closed does not block a data grant and does not cancel the tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active-low |
| core_req | input | 1 | Core asks for a bus transaction (level, held until tenure_done) |
| core_addr_only | input | 1 | The requested transaction has no data phase |
| abus_gnt_n | input | 1 | Address-bus grant |
| aack_n | input | 1 | Address acknowledge |
| artry_n | input | 1 | Address retry |
| dbus_gnt_n | input | 1 | Data-bus grant |
| dbusy_in_n | input | 1 | Data bus busy with another master |
| drtry_n | input | 1 | Data retry |
| ta_n | input | 1 | Transfer acknowledge, one per data beat |
| breq_n | output | 1 | Address-bus request |
| tstart_n | output | 1 | Transfer start strobe |
| dtenure_n | output | 1 | Low while the block owns the data bus |
| tenure_done | output | 1 | One-cycle completion pulse to the core |

## Verification
The hardest case to reach is a retry that lands after the burst has fully arrived but while the retry window is still open. The bench reaches it by holding off the address acknowledge for six cycles while granting the data bus at once, so all four beats finish before the late retry comes. It then checks that the data tenure is dropped, that a second transfer start follows, and that completion waits for a fresh burst. Retries placed exactly one cycle before and one cycle after the window, plus a foreign retry that coincides with the data grant, pin down both window edges.

// File: rtl/tenure_pkg.sv
package tenure_pkg;

  typedef enum logic [3:0] {
    A_IDLE,
    A_REQ,
    A_SNOOP,
    A_TS,
    A_ADDR,
    A_ACKED,
    A_RELEASE,
    A_WAITDATA,
    A_DONE
  } addr_st_t;

  typedef enum logic [1:0] {
    D_IDLE,
    D_WAIT,
    D_XFER,
    D_FULL
  } data_st_t;

  // saturating age counter step
  function automatic int unsigned age_step(input int unsigned age, input int unsigned limit);
    return (age < limit) ? age + 1 : age;
  endfunction

  // retry is honoured once the age since the strobe reaches the minimum
  function automatic logic window_open(input int unsigned age, input int unsigned min_age);
    return age >= min_age;
  endfunction

  // the beat being acknowledged now is the final one of the burst
  function automatic logic final_beat(input int unsigned cnt, input int unsigned beats);
    return (cnt + 1) == beats;
  endfunction

endpackage

// File: rtl/addr_tenure_fsm.sv
module addr_tenure_fsm
  import tenure_pkg::*;
#(
  parameter int unsigned RETRY_MIN_AGE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_req,
  input  logic core_addr_only,
  input  logic abus_gnt_n,
  input  logic aack_n,
  input  logic artry_n,
  input  logic data_full,
  output logic breq_n,
  output logic tstart_n,
  output logic data_start,
  output logic own_retry,
  output logic tenure_done
);

  localparam int unsigned AGE_W = (RETRY_MIN_AGE > 0) ? $clog2(RETRY_MIN_AGE + 1) : 1;

  addr_st_t           st_q, st_d;
  logic [AGE_W-1:0]   age_q, age_d;
  logic               retried_q, retried_d;
  logic               ao_q, ao_d;

  always_comb begin
    st_d      = st_q;
    age_d     = age_q;
    retried_d = retried_q;
    ao_d      = ao_q;
    own_retry = 1'b0;
    case (st_q)
      A_IDLE: begin
        if (core_req) begin
          st_d = A_REQ;
          ao_d = core_addr_only;
        end
      end
      A_REQ: begin
        if (!artry_n)         st_d = A_SNOOP;
        else if (!abus_gnt_n) st_d = A_TS;
      end
      A_SNOOP: begin
        if (artry_n) st_d = A_REQ;
      end
      A_TS: begin
        st_d      = A_ADDR;
        age_d     = AGE_W'(1);
        retried_d = 1'b0;
      end
      A_ADDR: begin
        own_retry = !artry_n && window_open(int'(age_q), RETRY_MIN_AGE);
        age_d     = AGE_W'(age_step(int'(age_q), RETRY_MIN_AGE));
        if (own_retry) retried_d = 1'b1;
        if (!aack_n)   st_d = A_ACKED;
      end
      A_ACKED: begin
        own_retry = !artry_n;
        if (own_retry) retried_d = 1'b1;
        st_d = A_RELEASE;
      end
      A_RELEASE: begin
        // retry line may be indeterminate here: not sampled
        if (retried_q)               st_d = A_REQ;
        else if (ao_q || data_full)  st_d = A_DONE;
        else                         st_d = A_WAITDATA;
      end
      A_WAITDATA: begin
        if (data_full) st_d = A_DONE;
      end
      A_DONE: begin
        st_d = A_IDLE;
      end
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= A_IDLE;
      age_q     <= '0;
      retried_q <= 1'b0;
      ao_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      age_q     <= age_d;
      retried_q <= retried_d;
      ao_q      <= ao_d;
    end
  end

  assign breq_n      = !((st_q == A_REQ) && artry_n);
  assign tstart_n    = (st_q != A_TS);
  assign data_start  = (st_q == A_TS) && !ao_q;
  assign tenure_done = (st_q == A_DONE);

  assert_ts_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tstart_n |=> tstart_n)
    else $error("transfer start held longer than one cycle");

  assert_snoop_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == A_REQ && !artry_n) |=> breq_n)
    else $error("request not withdrawn after snooper retry");

  assert_retry_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    own_retry |=> (breq_n && tstart_n && !tenure_done))
    else $error("bus activity right after an honoured retry");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_done |=> !tenure_done)
    else $error("completion pulse wider than one cycle");

endmodule

// File: rtl/grant_qualifier.sv
module grant_qualifier (
  input  logic dbus_gnt_n,
  input  logic dbusy_in_n,
  input  logic drtry_n,
  input  logic own_retry,
  output logic qual_gnt
);

  // retries of other pipelined tenures never reach own_retry
  assign qual_gnt = !dbus_gnt_n && dbusy_in_n && drtry_n && !own_retry;

endmodule

// File: rtl/data_tenure_ctl.sv
module data_tenure_ctl
  import tenure_pkg::*;
#(
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_start,
  input  logic qual_gnt,
  input  logic ta_n,
  input  logic drtry_n,
  input  logic cancel,
  input  logic finish,
  output logic dtenure_n,
  output logic data_full
);

  localparam int unsigned BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

  data_st_t          dst_q, dst_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    dst_d  = dst_q;
    beat_d = beat_q;
    case (dst_q)
      D_IDLE: begin
        if (data_start) dst_d = D_WAIT;
      end
      D_WAIT: begin
        if (cancel) dst_d = D_IDLE;
        else if (qual_gnt) begin
          dst_d  = D_XFER;
          beat_d = '0;
        end
      end
      D_XFER: begin
        if (cancel) begin
          dst_d  = D_IDLE;
          beat_d = '0;
        end else if (!drtry_n) begin
          beat_d = '0;
        end else if (!ta_n) begin
          if (final_beat(int'(beat_q), BURST_BEATS)) begin
            dst_d  = D_FULL;
            beat_d = '0;
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
      end
      D_FULL: begin
        if (cancel || finish) dst_d = D_IDLE;
      end
      default: dst_d = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= D_IDLE;
      beat_q <= '0;
    end else begin
      dst_q  <= dst_d;
      beat_q <= beat_d;
    end
  end

  assign dtenure_n = (dst_q != D_XFER);
  assign data_full = (dst_q == D_FULL);

  assert_grant_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtenure_n) |-> $past(qual_gnt))
    else $error("data tenure began without a qualified grant");

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (dtenure_n && !data_full))
    else $error("data tenure survived an address retry");

  assert_full_on_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_full) |-> $past(!ta_n && drtry_n))
    else $error("burst completed without a final beat");

endmodule

// File: rtl/bus_tenure_seq.sv
module bus_tenure_seq
  import tenure_pkg::*;
#(
  parameter int unsigned RETRY_MIN_AGE = 2,
  parameter int unsigned BURST_BEATS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_req,
  input  logic core_addr_only,
  input  logic abus_gnt_n,
  input  logic aack_n,
  input  logic artry_n,
  input  logic dbus_gnt_n,
  input  logic dbusy_in_n,
  input  logic drtry_n,
  input  logic ta_n,
  output logic breq_n,
  output logic tstart_n,
  output logic dtenure_n,
  output logic tenure_done
);

  logic data_start;
  logic own_retry;
  logic data_full;
  logic qual_gnt;

  addr_tenure_fsm #(
    .RETRY_MIN_AGE(RETRY_MIN_AGE)
  ) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_req      (core_req),
    .core_addr_only(core_addr_only),
    .abus_gnt_n    (abus_gnt_n),
    .aack_n        (aack_n),
    .artry_n       (artry_n),
    .data_full     (data_full),
    .breq_n        (breq_n),
    .tstart_n      (tstart_n),
    .data_start    (data_start),
    .own_retry     (own_retry),
    .tenure_done   (tenure_done)
  );

  grant_qualifier u_qual (
    .dbus_gnt_n(dbus_gnt_n),
    .dbusy_in_n(dbusy_in_n),
    .drtry_n   (drtry_n),
    .own_retry (own_retry),
    .qual_gnt  (qual_gnt)
  );

  data_tenure_ctl #(
    .BURST_BEATS(BURST_BEATS)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_start(data_start),
    .qual_gnt  (qual_gnt),
    .ta_n      (ta_n),
    .drtry_n   (drtry_n),
    .cancel    (own_retry),
    .finish    (tenure_done),
    .dtenure_n (dtenure_n),
    .data_full (data_full)
  );

endmodule

// File: tb/tb_bus_tenure_seq.sv
module tb_bus_tenure_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req = 1'b0, core_addr_only = 1'b0;
  logic abus_gnt_n = 1'b1, aack_n = 1'b1, artry_n = 1'b1;
  logic dbus_gnt_n = 1'b1, dbusy_in_n = 1'b1, drtry_n = 1'b1, ta_n = 1'b1;
  logic breq_n, tstart_n, dtenure_n, tenure_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_tenure_seq dut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr_only(core_addr_only),
    .abus_gnt_n(abus_gnt_n), .aack_n(aack_n), .artry_n(artry_n),
    .dbus_gnt_n(dbus_gnt_n), .dbusy_in_n(dbusy_in_n), .drtry_n(drtry_n), .ta_n(ta_n),
    .breq_n(breq_n), .tstart_n(tstart_n), .dtenure_n(dtenure_n), .tenure_done(tenure_done)
  );

  // ao: address-only; a: ack offset; rt: retry offset (0 none, first attempt only);
  // g: first cycle dbusy_in_n is high; d: data-retry offset (0 none). Offsets from strobe.
  typedef struct packed {
    logic       ao;
    logic [7:0] a;
    logic [7:0] rt;
    logic [7:0] g;
    logic [7:0] d;
    logic [7:0] tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd2, 8'd0, 8'd1, 8'd0, 8'd8},   // R8 plain burst, early ack
    '{1'b0, 8'd6, 8'd0, 8'd1, 8'd0, 8'd9},   // R9 late ack sets completion
    '{1'b1, 8'd3, 8'd0, 8'd1, 8'd0, 8'd11},  // R11 address-only
    '{1'b0, 8'd3, 8'd3, 8'd1, 8'd0, 8'd6},   // R6 retry on ack cycle, mid-burst
    '{1'b0, 8'd6, 8'd7, 8'd1, 8'd0, 8'd7},   // R7 retry after full burst received
    '{1'b0, 8'd3, 8'd1, 8'd1, 8'd0, 8'd5},   // R5 retry too early, ignored
    '{1'b0, 8'd3, 8'd5, 8'd1, 8'd0, 8'd5},   // R5 retry on release cycle, ignored
    '{1'b0, 8'd2, 8'd0, 8'd4, 8'd0, 8'd4},   // R4 grant held off by busy
    '{1'b0, 8'd2, 8'd0, 8'd1, 8'd4, 8'd10},  // R10 data retry mid-burst
    '{1'b0, 8'd2, 8'd5, 8'd5, 8'd0, 8'd12},  // R12 foreign retry with the grant
    '{1'b1, 8'd2, 8'd2, 8'd1, 8'd0, 8'd6},   // R6 address-only retried
    '{1'b0, 8'd4, 8'd4, 8'd1, 8'd0, 8'd7}    // R7 retry cancels running burst
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit retry_valid(input vec_t v);
    return (v.rt >= 2) && (int'(v.rt) <= int'(v.a) + 1);
  endfunction

  // completion offset of a single attempt, from its strobe
  function automatic int attempt_done(input vec_t v);
    int last;
    if (v.ao) return int'(v.a) + 3;
    last = (v.d != 0) ? int'(v.d) + 4 : int'(v.g) + 4;
    return (int'(v.a) + 3 > last + 2) ? int'(v.a) + 3 : last + 2;
  endfunction

  function automatic int exp_done(input vec_t v);
    return retry_valid(v) ? int'(v.a) + 4 + attempt_done(v) : attempt_done(v);
  endfunction

  function automatic int exp_xfer(input vec_t v);
    if (v.ao) return 0;
    return (v.d != 0) ? int'(v.d) + 4 - int'(v.g) : 4;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    core_req = 1'b0; abus_gnt_n = 1'b1; aack_n = 1'b1; artry_n = 1'b1;
    dbus_gnt_n = 1'b1; dbusy_in_n = 1'b1; drtry_n = 1'b1; ta_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(breq_n && tstart_n && dtenure_n && !tenure_done, "R1 idle after reset",
        {breq_n, tstart_n, dtenure_n, tenure_done}, 4'b1110);
  endtask

  task automatic run_vec(input vec_t v);
    int r = -1, t = -1, ts_cnt = 0, done_cnt = 0, done_at = -1, xfer = 0, post = 0;
    string tg = $sformatf("R%0d", v.tag);
    core_addr_only = v.ao;
    abus_gnt_n = 1'b0;
    dbus_gnt_n = 1'b0;
    for (int cyc = 0; cyc < 120 && post < 3; cyc++) begin
      @(negedge clk);
      if (!tstart_n) begin
        ts_cnt++; r = 0; xfer = 0;
        if (t < 0) t = 0; else t++;
      end else begin
        if (r >= 0) r++;
        if (t >= 0) t++;
      end
      if (!dtenure_n) xfer++;
      if (tenure_done) begin
        done_cnt++;
        if (done_at < 0) done_at = t;
      end
      if (done_cnt > 0) post++;
      if (ts_cnt == 1 && retry_valid(v) && !v.ao && r == int'(v.rt) + 1)
        chk(dtenure_n, "R7 data dropped after retry", dtenure_n, 1);
      core_req   = (done_cnt == 0);
      aack_n     = !(r >= 0 && r == int'(v.a));
      artry_n    = !(ts_cnt == 1 && v.rt != 0 && r == int'(v.rt));
      dbusy_in_n = !(r >= 1 && r < int'(v.g));
      drtry_n    = !(v.d != 0 && r == int'(v.d));
      ta_n       = dtenure_n;
    end
    chk(done_at == exp_done(v), {tg, " completion cycle"}, done_at, exp_done(v));
    chk(ts_cnt == (retry_valid(v) ? 2 : 1), "R6 transfer starts (R2 one cycle each)",
        ts_cnt, retry_valid(v) ? 2 : 1);
    chk(xfer == exp_xfer(v), {tg, " data tenure cycles"}, xfer, exp_xfer(v));
    chk(done_cnt == 1, "R9 single completion pulse", done_cnt, 1);
    aack_n = 1'b1; artry_n = 1'b1; dbusy_in_n = 1'b1; drtry_n = 1'b1; ta_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 / R3 / R4 directed sequence
    @(negedge clk);
    core_req = 1'b1; abus_gnt_n = 1'b1;
    @(negedge clk);
    chk(!breq_n, "R2 request next cycle", breq_n, 0);
    artry_n = 1'b0;
    #1 chk(breq_n, "R3 request dropped same cycle", breq_n, 1);
    @(negedge clk);
    chk(breq_n, "R3 request still withdrawn", breq_n, 1);
    artry_n = 1'b1;
    @(negedge clk);
    chk(!breq_n, "R3 request restored", breq_n, 0);
    abus_gnt_n = 1'b0;
    @(negedge clk);
    chk(!tstart_n && breq_n, "R2 strobe after grant", {tstart_n, breq_n}, 2'b01);
    dbus_gnt_n = 1'b0; drtry_n = 1'b0;
    @(negedge clk);
    chk(tstart_n, "R2 strobe lasts one cycle", tstart_n, 1);
    chk(dtenure_n, "R4 grant blocked by data retry", dtenure_n, 1);
    drtry_n = 1'b1;
    @(negedge clk);
    chk(!dtenure_n, "R4 qualified grant starts tenure", dtenure_n, 0);
    do_reset();

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule